// File: doc/BRIEF.md
# Multilevel Hysteresis Level Selector

This block chooses the output voltage level of one phase leg of an N-level inverter under time-based double-band hysteresis current control. Five comparator bits describe the current error, defined as measured current minus demanded current. Two bits give its position against the inner band, two give its position against the outer band, and one gives the sign of its slope. From these bits the block decides every clock cycle whether to hold the present level or move it one step up or down. The chosen level leaves as a signed index for a gate decoder.

In normal operation the error lies inside the inner band and the level is held. When the error leaves the inner band and is still moving away, the level steps one position toward the correcting side. Stepping continues until the slope shows the error heading back, and then the level is held. When the error also lies outside the outer band, the slope is ignored and the level runs to the extreme level on the correcting side. After every level change a lockout timer freezes further decisions, which gives each level a minimum dwell time. The comparator bits are asynchronous and pass through a two-flop synchroniser. The pins are plain control signals with no valid/ready handshake: the level is a continuously driven value that the decoder samples every cycle, so there is no back-pressure.

Top module: `mlhc_level_fsm`

## Requirements
- R1: While `rst_n` is low and on release, `level_o` is 0 and the lockout is clear, so a qualifying input can move the level without waiting.
- R2: The inputs are encoded with 1 meaning the error is above the limit. When `inner_hi`=1 and the slope bit `slope_rise`=1, the level drops by exactly one. When `inner_lo`=0 and `slope_rise`=0, the level rises by exactly one. `inner_hi`=1 takes priority over `inner_lo`=0, and no change is ever larger than one step.
- R3: Within the outer band (`outer_hi`=0, `outer_lo`=1), the level is held in two cases: when the error is above the inner band with `slope_rise`=0, and when it is below the inner band with `slope_rise`=1.
- R4: With the error inside the inner band (`inner_hi`=0, `inner_lo`=1), the level is held whatever the slope bit does.
- R5: Two level changes are always at least `LOCKOUT_CYCLES` clock cycles apart.
- R6: With `inner_hi`=1 and `outer_hi`=1, the level keeps dropping whatever the slope until it reaches the lowest level. With `inner_lo`=0 and `outer_lo`=0, it keeps rising until it reaches the highest level.
- R7: At the highest level an up request leaves the level unchanged, and at the lowest level a down request does the same.
- R8: `level_o` is two's complement in the range -(N-1)/2 to +(N-1)/2 for `NUM_LEVELS` N of 3, 5 or 7. The port is 2 bits wide for 3 levels and 3 bits wide for 5 or 7 levels.
- R9: A change on the comparator inputs affects `level_o` on the third rising clock edge after it: two synchroniser stages, then the level register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inner_hi | input | 1 | 1 when the error is above the upper inner limit |
| inner_lo | input | 1 | 1 when the error is above the lower inner limit |
| outer_hi | input | 1 | 1 when the error is above the upper outer limit |
| outer_lo | input | 1 | 1 when the error is above the lower outer limit |
| slope_rise | input | 1 | 1 when the error is increasing |
| level_o | output | LVL_W | Selected level, signed two's complement |

## Verification
The only state is the level, the lockout count and the synchroniser stages, and each of them shows at `level_o`. A wrong level appears at once as a wrong value on the port. A lockout count that is off by one moves the second step of a multi-step run by one cycle, and the bench samples that run cycle-exactly. A missing slope gate or a missing outer-band override shows within one lockout period as a level that either keeps moving when it should stop or stops short of the extreme. An extra or missing synchroniser stage shows as a first step one cycle early or late.

// File: rtl/mlhc_pkg.sv
package mlhc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Bit order of the packed comparator vector.
  localparam int CMP_IH = 4;
  localparam int CMP_IL = 3;
  localparam int CMP_OH = 2;
  localparam int CMP_OL = 1;
  localparam int CMP_SR = 0;
  localparam int CMP_W  = 5;

  // Neutral pattern: inside both bands, slope falling.
  localparam logic [CMP_W-1:0] CMP_NEUTRAL = 5'b01010;
endpackage

// File: rtl/mlhc_sync.sv
module mlhc_sync #(
  parameter int              W       = 5,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // R9: second stage follows first stage by exactly one cycle
  assert_sync_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == $past(meta_q));
endmodule

// File: rtl/mlhc_lockout.sv
module mlhc_lockout #(
  parameter int LOCKOUT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  generate
    if (LOCKOUT_CYCLES <= 1) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int CW = $clog2(LOCKOUT_CYCLES);
      localparam logic [CW-1:0] RELOAD = CW'(LOCKOUT_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (load) begin
          cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign busy = (cnt_q != '0);

      // R5: a level change always arms the lockout
      assert_lockout_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
      // R5: no reload is requested while the lockout is running
      assert_no_load_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
    end
  endgenerate
endmodule

// File: rtl/mlhc_step_decide.sv
module mlhc_step_decide
  import mlhc_pkg::*;
(
  input  logic  above_inner,
  input  logic  above_inner_lo,
  input  logic  above_outer,
  input  logic  above_outer_lo,
  input  logic  rising,
  input  logic  at_top,
  input  logic  at_bottom,
  input  logic  frozen,
  output step_e step
);
  logic too_high;
  logic too_low;
  logic push_down;
  logic push_up;

  assign too_high  = above_inner;
  assign too_low   = !above_inner_lo && !above_inner;
  // Outer band violation masks the slope term.
  assign push_down = too_high && (rising || above_outer);
  assign push_up   = too_low  && (!rising || !above_outer_lo);

  always_comb begin
    step = STEP_HOLD;
    if (!frozen) begin
      if (push_down && !at_bottom) begin
        step = STEP_DOWN;
      end else if (push_up && !at_top) begin
        step = STEP_UP;
      end
    end
  end
endmodule

// File: rtl/mlhc_level_fsm.sv
module mlhc_level_fsm
  import mlhc_pkg::*;
#(
  parameter int NUM_LEVELS     = 5,
  parameter int LOCKOUT_CYCLES = 4,
  parameter int LVL_W          = $clog2(NUM_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inner_hi,
  input  logic             inner_lo,
  input  logic             outer_hi,
  input  logic             outer_lo,
  input  logic             slope_rise,
  output logic [LVL_W-1:0] level_o
);
  localparam int LVL_SPAN = (NUM_LEVELS - 1) / 2;
  localparam logic signed [LVL_W-1:0] LVL_TOP = LVL_W'(LVL_SPAN);
  localparam logic signed [LVL_W-1:0] LVL_BOT = LVL_W'(-LVL_SPAN);
  localparam int DW = $clog2(LOCKOUT_CYCLES + 1) + 1;

  logic [CMP_W-1:0] cmp_raw;
  logic [CMP_W-1:0] cmp_s;
  logic             frozen;
  logic             changing;
  step_e            step;
  logic signed [LVL_W-1:0] lvl_q;
  logic signed [LVL_W-1:0] lvl_d;

  assign cmp_raw[CMP_IH] = inner_hi;
  assign cmp_raw[CMP_IL] = inner_lo;
  assign cmp_raw[CMP_OH] = outer_hi;
  assign cmp_raw[CMP_OL] = outer_lo;
  assign cmp_raw[CMP_SR] = slope_rise;

  mlhc_sync #(.W(CMP_W), .RST_VAL(CMP_NEUTRAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_raw),
    .q     (cmp_s)
  );

  mlhc_step_decide u_decide (
    .above_inner    (cmp_s[CMP_IH]),
    .above_inner_lo (cmp_s[CMP_IL]),
    .above_outer    (cmp_s[CMP_OH]),
    .above_outer_lo (cmp_s[CMP_OL]),
    .rising         (cmp_s[CMP_SR]),
    .at_top         (lvl_q == LVL_TOP),
    .at_bottom      (lvl_q == LVL_BOT),
    .frozen         (frozen),
    .step           (step)
  );

  assign changing = (step != STEP_HOLD);

  mlhc_lockout #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (changing),
    .busy  (frozen)
  );

  always_comb begin
    unique case (step)
      STEP_UP:   lvl_d = lvl_q + 1'b1;
      STEP_DOWN: lvl_d = lvl_q - 1'b1;
      default:   lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  // Cycles since the last level change, saturating; used only by checks.
  logic [DW-1:0] dwell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= DW'(LOCKOUT_CYCLES);
    end else if (lvl_q != lvl_d) begin
      dwell_q <= '0;
    end else if (dwell_q < DW'(LOCKOUT_CYCLES)) begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  assert_level_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q >= LVL_BOT) && (lvl_q <= LVL_TOP));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |->
      ((int'(lvl_q) - int'($past(lvl_q)) == 1) || (int'(lvl_q) - int'($past(lvl_q)) == -1)));

  assert_lockout_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (int'($past(dwell_q)) >= LOCKOUT_CYCLES - 1));

  assert_down_needs_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q < $past(lvl_q)) |-> $past(cmp_s[CMP_IH]));

  assert_up_needs_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q > $past(lvl_q)) |-> $past(!cmp_s[CMP_IL]));

  assert_reversal_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_s[CMP_IH] && !cmp_s[CMP_SR] && !cmp_s[CMP_OH]) |-> (lvl_q >= $past(lvl_q)));

  assert_outer_pushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_s[CMP_IH] && cmp_s[CMP_OH] && !frozen && (lvl_q != LVL_BOT))
      |-> (int'(lvl_q) == int'($past(lvl_q)) - 1));

  assert_inband_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmp_s[CMP_IH] && cmp_s[CMP_IL]) |-> (lvl_q == $past(lvl_q)));
endmodule

// File: tb/test_mlhc_level_fsm.sv
module test_mlhc_level_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ih = 1'b0, il = 1'b1, oh = 1'b0, ol = 1'b1, sr = 1'b0;
  logic signed [2:0] lv5;
  logic signed [1:0] lv3;
  logic signed [2:0] lv7;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlhc_level_fsm #(.NUM_LEVELS(5), .LOCKOUT_CYCLES(LOCK)) i_mlhc_level_fsm (
    .clk(clk), .rst_n(rst_n), .inner_hi(ih), .inner_lo(il),
    .outer_hi(oh), .outer_lo(ol), .slope_rise(sr), .level_o(lv5));

  mlhc_level_fsm #(.NUM_LEVELS(3), .LOCKOUT_CYCLES(LOCK)) i_mlhc_level_fsm_l3 (
    .clk(clk), .rst_n(rst_n), .inner_hi(ih), .inner_lo(il),
    .outer_hi(oh), .outer_lo(ol), .slope_rise(sr), .level_o(lv3));

  mlhc_level_fsm #(.NUM_LEVELS(7), .LOCKOUT_CYCLES(LOCK)) i_mlhc_level_fsm_l7 (
    .clk(clk), .rst_n(rst_n), .inner_hi(ih), .inner_lo(il),
    .outer_hi(oh), .outer_lo(ol), .slope_rise(sr), .level_o(lv7));

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: level actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b, input logic x, input logic y, input logic c);
    ih = a; il = b; oh = x; ol = y; sr = c;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    cyc(3);
    check("R1", lv5, 0);
    check("R1", lv7, 0);
    rst_n = 1'b1;
  endtask

  // R1 / R4: reset value, then in-band hold under slope toggling
  task automatic t_reset_and_inband();
    do_reset();
    for (int i = 0; i < 10; i++) begin
      sr = ~sr;
      cyc(2);
    end
    check("R4", lv5, 0);
    check("R4", lv3, 0);
  endtask

  // R2 / R3 / R9: one step down, then slope reversal stops stepping
  task automatic t_step_then_stop();
    do_reset();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    cyc(2);
    check("R9", lv5, 0);
    cyc(1);
    check("R2", lv5, -1);
    sr = 1'b0;
    cyc(12);
    check("R3", lv5, -1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    cyc(10);
    check("R4", lv5, -1);
  endtask

  // R3: above band but already heading back, inside outer band: hold
  task automatic t_above_falling_hold();
    do_reset();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc(15);
    check("R3", lv5, 0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc(15);
    check("R3", lv5, 0);
  endtask

  // R5 / R7: continued stepping down with lockout spacing, then saturation
  task automatic t_lockout_and_floor();
    do_reset();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    cyc(3);
    check("R5", lv5, -1);
    cyc(LOCK - 1);
    check("R5", lv5, -1);
    cyc(1);
    check("R5", lv5, -2);
    cyc(20);
    check("R7", lv5, -2);
    check("R7", lv3, -1);
  endtask

  // R6: outer band overrides slope; run to extreme on each size
  task automatic t_outer_down();
    do_reset();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(3);
    check("R6", lv7, -1);
    cyc(LOCK);
    check("R6", lv7, -2);
    cyc(LOCK);
    check("R6", lv7, -3);
    check("R6", lv5, -2);
    cyc(10);
    check("R7", lv7, -3);
    check("R8", lv3, -1);
  endtask

  task automatic t_outer_up();
    do_reset();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(3);
    check("R6", lv3, 1);
    cyc(2 * LOCK - 1);
    check("R6", lv7, 2);
    cyc(1 + LOCK);
    check("R6", lv7, 3);
    check("R6", lv5, 2);
    cyc(10);
    check("R7", lv3, 1);
    check("R8", lv7, 3);
  endtask

  // R2 / R5: full traverse upward from the floor, step by step
  task automatic t_traverse_up();
    do_reset();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(3 + LOCK + 10);
    check("R6", lv5, -2);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(3);
    check("R2", lv5, -1);
    cyc(LOCK);
    check("R2", lv5, 0);
    cyc(LOCK);
    check("R2", lv5, 1);
    cyc(LOCK);
    check("R2", lv5, 2);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sr = ~sr;
      cyc(3);
    end
    check("R4", lv5, 2);
  endtask

  // R2: above upper and below lower both claimed: upper wins (down)
  task automatic t_priority();
    do_reset();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc(3);
    check("R2", lv5, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_and_inband();
    t_step_then_stop();
    t_above_falling_hold();
    t_lockout_and_floor();
    t_outer_down();
    t_outer_up();
    t_traverse_up();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule